// File: doc/BRIEF.md
# Burst-of-Four Wide-Array SRAM Datapath

This block models the data path of a synchronous common-I/O SRAM whose internal storage is four beats wide. The external side moves one beat per clock. A load strobe starts a burst of four beats, and a read/write select picks the direction. On a write, the four incoming beats and their per-lane enables are gathered into one wide word, which is committed to storage as a single late write. On a read, one wide word is fetched and sent out beat by beat, each beat marked by a valid flag.

The order of the beats inside a burst is linear and wraps around the wide word. In critical-word-first mode the two low address bits choose the starting beat. In fixed mode the burst always starts at beat zero and those two bits are ignored. A finished write stays in a pending register until the next write finishes. Reads look past this register so they always return the newest data.

Top module: `sdr_b4_core`

## Requirements
- R1: A read load accepted at rising edge t makes rvalid_o high for exactly four consecutive cycles, after edges t+RD_LAT through t+RD_LAT+3. rdata_o is zero whenever rvalid_o is low.
- R2: A write load accepted at edge t takes its four data beats and lane enables at edges t+1 through t+4. These beats become one wide-word update, visible to any later read.
- R3: With CWF=1, the two low address bits give the start slot s. Burst beat k uses wide-word slot (s+k) mod 4, for both writes and reads.
- R4: With CWF=0, the two low address bits are ignored. Beat k always uses slot k. Only addr_i[AW-1:2] selects the wide word.
- R5: Lane j of a beat covers bits j*LANE_W to j*LANE_W+LANE_W-1. If a lane's enable is low for a beat, the stored value of that lane in that slot is unchanged.
- R6: A read issued right after a write returns the newly written lanes, merged over the older contents. This holds while the write is still pending and also after it has been committed.
- R7: A load strobe arriving while a burst is in progress (edges t+1 to t+4 after an accepted load) is ignored. The next load can be accepted at edge t+5.
- R8: After reset, rvalid_o and rdata_o are zero and every wide word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_i | input | 1 | Load strobe that starts a burst |
| rnw_i | input | 1 | 1 = read burst, 0 = write burst (sampled with ld_i) |
| addr_i | input | IDX_W+2 | Address: upper bits select the wide word, the two low bits select the start slot |
| lane_we_i | input | DW/LANE_W | Per-lane write enables for the current write beat |
| wdata_i | input | DW | Write data beat |
| rdata_o | output | DW | Read data beat |
| rvalid_o | output | 1 | Read beat valid |

## Verification
Two instances run side by side on the same stimulus: one in critical-word-first mode and one in fixed mode. A wrong start slot or a wrong order therefore shows up as a mismatch in one instance and not in the other. Directed bursts read one fully written word from each of the four start slots, which separates a correct wrap from an offset that does not wrap. Partial-lane writes followed at once by reads tell the pending-register bypass apart from the committed array contents. A load held high during a write burst shows whether busy-time strobes are really ignored. A seeded random mix of addresses, start slots and lane masks then covers back-to-back write and read combinations against a bench model of the storage.

// File: rtl/sdr_b4_pkg.sv
package sdr_b4_pkg;

    localparam int unsigned BURST_LEN = 4;

    typedef logic [1:0] beat_t;

    typedef enum logic {
        OP_RD = 1'b0,
        OP_WR = 1'b1
    } op_e;

    // slot touched by beat k of a burst that starts at slot s (wraps mod 4)
    function automatic beat_t wrap_slot(input beat_t s, input beat_t k);
        return beat_t'(s + k);
    endfunction

endpackage

// File: rtl/sdr_b4_wdemux.sv
module sdr_b4_wdemux
    import sdr_b4_pkg::*;
#(
    parameter int unsigned DW    = 16,
    parameter int unsigned LANES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      beat_en_i,
    input  logic                      last_i,
    input  beat_t                     slot_i,
    input  logic [LANES-1:0]          we_i,
    input  logic [DW-1:0]             data_i,
    output logic                      done_o,
    output logic [BURST_LEN*DW-1:0]   wide_data_o,
    output logic [BURST_LEN*LANES-1:0] wide_mask_o
);

    typedef struct packed {
        logic [BURST_LEN-1:0][DW-1:0]    data;
        logic [BURST_LEN-1:0][LANES-1:0] mask;
    } acc_t;

    acc_t st_q, st_d;
    logic [BURST_LEN-1:0][DW-1:0]    cur_data;
    logic [BURST_LEN-1:0][LANES-1:0] cur_mask;

    always_comb begin
        cur_data = st_q.data;
        cur_mask = st_q.mask;
        if (beat_en_i) begin
            cur_data[slot_i] = data_i;
            cur_mask[slot_i] = we_i;
        end
        done_o      = beat_en_i && last_i;
        wide_data_o = cur_data;
        wide_mask_o = cur_mask;

        st_d.data = cur_data;
        st_d.mask = done_o ? '0 : cur_mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2: the accumulator starts every burst with no lanes marked
    p_clear_after_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (st_q.mask == '0) || beat_en_i);

endmodule

// File: rtl/sdr_b4_array.sv
module sdr_b4_array
    import sdr_b4_pkg::*;
#(
    parameter int unsigned DW     = 16,
    parameter int unsigned LANE_W = 8,
    parameter int unsigned IDX_W  = 6
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 commit_i,
    input  logic [IDX_W-1:0]                     commit_idx_i,
    input  logic [BURST_LEN*DW-1:0]              commit_data_i,
    input  logic [BURST_LEN*(DW/LANE_W)-1:0]     commit_mask_i,
    input  logic [IDX_W-1:0]                     look_idx_i,
    output logic [BURST_LEN*DW-1:0]              look_data_o
);

    localparam int unsigned LANES  = DW / LANE_W;
    localparam int unsigned WLANES = BURST_LEN * LANES;
    localparam int unsigned WIDE   = BURST_LEN * DW;
    localparam int unsigned DEPTH  = 1 << IDX_W;

    typedef struct packed {
        logic              vld;
        logic [IDX_W-1:0]  idx;
        logic [WIDE-1:0]   data;
        logic [WLANES-1:0] mask;
    } pend_t;

    pend_t           pend_q, pend_d;
    logic [WIDE-1:0] mem_q [DEPTH];
    logic            wr_en_d;
    logic [IDX_W-1:0] wr_idx_d;
    logic [WIDE-1:0] wr_word_d;
    logic [WIDE-1:0] old_word;
    logic [WIDE-1:0] seen_word;

    always_comb begin
        // retire the older pending write into storage, lane by lane
        old_word  = mem_q[pend_q.idx];
        wr_word_d = old_word;
        for (int l = 0; l < WLANES; l++) begin
            if (pend_q.mask[l]) begin
                wr_word_d[l*LANE_W +: LANE_W] = pend_q.data[l*LANE_W +: LANE_W];
            end
        end
        wr_en_d  = commit_i && pend_q.vld;
        wr_idx_d = pend_q.idx;

        pend_d = pend_q;
        if (commit_i) begin
            pend_d.vld  = 1'b1;
            pend_d.idx  = commit_idx_i;
            pend_d.data = commit_data_i;
            pend_d.mask = commit_mask_i;
        end

        // coherent lookup: pending lanes override stored lanes
        seen_word = mem_q[look_idx_i];
        if (pend_q.vld && (pend_q.idx == look_idx_i)) begin
            for (int l = 0; l < WLANES; l++) begin
                if (pend_q.mask[l]) begin
                    seen_word[l*LANE_W +: LANE_W] = pend_q.data[l*LANE_W +: LANE_W];
                end
            end
        end
        look_data_o = seen_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            pend_q <= pend_d;
            if (wr_en_d) begin
                mem_q[wr_idx_d] <= wr_word_d;
            end
        end
    end

    // R2: a completed write burst always lands in the pending register
    p_commit_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |=> (pend_q.vld && pend_q.idx == $past(commit_idx_i)));

    // R6: pending entry only changes when a new burst completes
    p_pending_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(pend_q));

endmodule

// File: rtl/sdr_b4_rmux.sv
module sdr_b4_rmux
    import sdr_b4_pkg::*;
#(
    parameter int unsigned DW     = 16,
    parameter int unsigned RD_LAT = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cap_i,
    input  logic [BURST_LEN*DW-1:0]  cap_word_i,
    input  logic                     active_i,
    input  beat_t                    slot_i,
    input  beat_t                    beat_i,
    output logic [DW-1:0]            rdata_o,
    output logic                     rvalid_o
);

    typedef struct packed {
        logic          vld;
        beat_t         beat;
        logic [DW-1:0] data;
    } stage_t;

    typedef struct packed {
        logic [BURST_LEN-1:0][DW-1:0] buf_w;
    } hold_t;

    hold_t  hold_q, hold_d;
    stage_t pipe_q [RD_LAT];
    stage_t pipe_d [RD_LAT];

    always_comb begin
        hold_d = hold_q;
        if (cap_i) begin
            hold_d.buf_w = cap_word_i;
        end

        pipe_d[0] = '0;
        if (active_i) begin
            pipe_d[0].vld  = 1'b1;
            pipe_d[0].beat = beat_i;
            pipe_d[0].data = hold_q.buf_w[slot_i];
        end
        for (int i = 1; i < RD_LAT; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end

        rvalid_o = pipe_q[RD_LAT-1].vld;
        rdata_o  = pipe_q[RD_LAT-1].data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            for (int i = 0; i < RD_LAT; i++) begin
                pipe_q[i] <= '0;
            end
        end else begin
            hold_q <= hold_d;
            for (int i = 0; i < RD_LAT; i++) begin
                pipe_q[i] <= pipe_d[i];
            end
        end
    end

    // R1: beats of one burst leave in unbroken ascending sequence
    p_beat_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_q[0].vld && pipe_q[0].beat != 2'd3)
            |=> (pipe_q[0].vld && pipe_q[0].beat == beat_t'($past(pipe_q[0].beat) + 2'd1)));

    // R1: the fourth beat closes the burst
    p_burst_end_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_q[0].vld && pipe_q[0].beat == 2'd3) |=> !pipe_q[0].vld);

    // R1: idle beats carry no data
    p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid_o |-> (rdata_o == '0));

endmodule

// File: rtl/sdr_b4_core.sv
module sdr_b4_core
    import sdr_b4_pkg::*;
#(
    parameter int unsigned DW     = 16,
    parameter int unsigned LANE_W = 8,
    parameter int unsigned IDX_W  = 6,
    parameter int unsigned RD_LAT = 2,
    parameter int unsigned CWF    = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ld_i,
    input  logic                     rnw_i,
    input  logic [IDX_W+1:0]         addr_i,
    input  logic [DW/LANE_W-1:0]     lane_we_i,
    input  logic [DW-1:0]            wdata_i,
    output logic [DW-1:0]            rdata_o,
    output logic                     rvalid_o
);

    localparam int unsigned LANES = DW / LANE_W;
    localparam int unsigned WIDE  = BURST_LEN * DW;

    typedef struct packed {
        logic [2:0]       left;
        op_e              op;
        beat_t            start;
        logic [IDX_W-1:0] idx;
    } ctl_t;

    ctl_t  c_q, c_d;
    logic  accept;
    beat_t beat_k;
    beat_t slot_k;
    logic  wr_beat;
    logic  rd_beat;
    logic  last_beat;
    logic  rd_cap;

    logic                    wr_done;
    logic [WIDE-1:0]         wr_wide;
    logic [BURST_LEN*LANES-1:0] wr_mask;
    logic [WIDE-1:0]         look_word;

    always_comb begin
        c_d    = c_q;
        accept = ld_i && (c_q.left == 3'd0);
        if (c_q.left != 3'd0) begin
            c_d.left = c_q.left - 3'd1;
        end
        if (accept) begin
            c_d.left  = 3'(BURST_LEN);
            c_d.op    = rnw_i ? OP_RD : OP_WR;
            c_d.start = (CWF != 0) ? addr_i[1:0] : 2'd0;
            c_d.idx   = addr_i[IDX_W+1:2];
        end

        beat_k    = beat_t'(3'(BURST_LEN) - c_q.left);
        slot_k    = wrap_slot(c_q.start, beat_k);
        last_beat = (c_q.left == 3'd1);
        wr_beat   = (c_q.left != 3'd0) && (c_q.op == OP_WR);
        rd_beat   = (c_q.left != 3'd0) && (c_q.op == OP_RD);
        rd_cap    = accept && rnw_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '{left: 3'd0, op: OP_RD, start: 2'd0, idx: '0};
        end else begin
            c_q <= c_d;
        end
    end

    sdr_b4_wdemux #(.DW(DW), .LANES(LANES)) u_wdemux (
        .clk         (clk),
        .rst_n       (rst_n),
        .beat_en_i   (wr_beat),
        .last_i      (last_beat),
        .slot_i      (slot_k),
        .we_i        (lane_we_i),
        .data_i      (wdata_i),
        .done_o      (wr_done),
        .wide_data_o (wr_wide),
        .wide_mask_o (wr_mask)
    );

    sdr_b4_array #(.DW(DW), .LANE_W(LANE_W), .IDX_W(IDX_W)) u_array (
        .clk           (clk),
        .rst_n         (rst_n),
        .commit_i      (wr_done),
        .commit_idx_i  (c_q.idx),
        .commit_data_i (wr_wide),
        .commit_mask_i (wr_mask),
        .look_idx_i    (addr_i[IDX_W+1:2]),
        .look_data_o   (look_word)
    );

    sdr_b4_rmux #(.DW(DW), .RD_LAT(RD_LAT)) u_rmux (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_i      (rd_cap),
        .cap_word_i (look_word),
        .active_i   (rd_beat),
        .slot_i     (slot_k),
        .beat_i     (beat_k),
        .rdata_o    (rdata_o),
        .rvalid_o   (rvalid_o)
    );

    // R7: a strobe during a burst neither restarts nor extends it
    p_busy_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.left != 3'd0 && ld_i) |=> (c_q.left == $past(c_q.left) - 3'd1));

    generate
        if (CWF == 0) begin : g_fixed_chk
            // R4: fixed mode never starts away from slot zero
            p_fixed_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (c_q.left != 3'd0) |-> (c_q.start == 2'd0));
        end
    endgenerate

endmodule

// File: tb/tb_sdr_b4_core.sv
module tb_sdr_b4_core;

    localparam int DW     = 16;
    localparam int LANE_W = 8;
    localparam int LANES  = DW / LANE_W;
    localparam int IDX_W  = 6;
    localparam int RD_LAT = 2;
    localparam int DEPTH  = 1 << IDX_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ld = 1'b0;
    logic              rnw = 1'b0;
    logic [IDX_W+1:0]  addr = '0;
    logic [LANES-1:0]  we = '0;
    logic [DW-1:0]     wdata = '0;
    logic [DW-1:0]     rdata_c, rdata_f;
    logic              rvalid_c, rvalid_f;

    int n_chk = 0;
    int n_err = 0;

    logic [DW-1:0] mem_c [DEPTH][4];
    logic [DW-1:0] mem_f [DEPTH][4];

    always #10 clk = ~clk;

    sdr_b4_core #(.DW(DW), .LANE_W(LANE_W), .IDX_W(IDX_W), .RD_LAT(RD_LAT), .CWF(1)) dut (
        .clk(clk), .rst_n(rst_n), .ld_i(ld), .rnw_i(rnw), .addr_i(addr),
        .lane_we_i(we), .wdata_i(wdata), .rdata_o(rdata_c), .rvalid_o(rvalid_c));

    sdr_b4_core #(.DW(DW), .LANE_W(LANE_W), .IDX_W(IDX_W), .RD_LAT(RD_LAT), .CWF(0)) dut_fixed (
        .clk(clk), .rst_n(rst_n), .ld_i(ld), .rnw_i(rnw), .addr_i(addr),
        .lane_we_i(we), .wdata_i(wdata), .rdata_o(rdata_f), .rvalid_o(rvalid_f));

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                            input logic [LANES-1:0] en);
        logic [DW-1:0] r = old;
        for (int j = 0; j < LANES; j++) begin
            if (en[j]) r[j*LANE_W +: LANE_W] = nw[j*LANE_W +: LANE_W];
        end
        return r;
    endfunction

    // write burst; when poke is set a read strobe is held during the beats (R7)
    task automatic do_write(input logic [IDX_W+1:0] a, input logic [3:0][DW-1:0] d,
                            input logic [3:0][LANES-1:0] en, input bit poke);
        int idx = int'(a[IDX_W+1:2]);
        int s   = int'(a[1:0]);
        @(negedge clk);
        ld = 1'b1; rnw = 1'b0; addr = a;
        @(posedge clk);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (poke) begin
                chk("R7", DW'(rvalid_c), DW'(0));
                ld = 1'b1; rnw = 1'b1; addr = ~a;
            end else begin
                ld = 1'b0;
            end
            wdata = d[k]; we = en[k];
            @(posedge clk);
        end
        for (int k = 0; k < 4; k++) begin
            mem_c[idx][(s + k) % 4] = merge(mem_c[idx][(s + k) % 4], d[k], en[k]);
            mem_f[idx][k]           = merge(mem_f[idx][k], d[k], en[k]);
        end
        @(negedge clk);
        ld = 1'b0; we = '0;
        if (poke) begin
            for (int c = 0; c < 4; c++) begin
                chk("R7", DW'(rvalid_c), DW'(0));
                chk("R7", DW'(rvalid_f), DW'(0));
                @(negedge clk);
            end
        end
    endtask

    task automatic do_read(input logic [IDX_W+1:0] a, input string req);
        int idx = int'(a[IDX_W+1:2]);
        int s   = int'(a[1:0]);
        @(negedge clk);
        ld = 1'b1; rnw = 1'b1; addr = a;
        @(posedge clk);
        @(negedge clk);
        ld = 1'b0;
        for (int c = 1; c <= RD_LAT + 3; c++) begin
            @(posedge clk);
            @(negedge clk);
            if (c < RD_LAT) begin
                chk("R1", DW'(rvalid_c), DW'(0));
            end else begin
                chk("R1", DW'(rvalid_c), DW'(1));
                chk(req, rdata_c, mem_c[idx][(s + c - RD_LAT) % 4]);
                chk("R4", DW'(rvalid_f), DW'(1));
                chk("R4", rdata_f, mem_f[idx][c - RD_LAT]);
            end
        end
        @(posedge clk);
        @(negedge clk);
        chk("R1", DW'(rvalid_c), DW'(0));
        chk("R1", rdata_c, '0);
    endtask

    initial begin
        #(20 * 200000);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [3:0][DW-1:0]    d;
        logic [3:0][LANES-1:0] en;
        int unsigned seed_v;
        seed_v = $urandom(32'd2024);
        for (int i = 0; i < DEPTH; i++)
            for (int k = 0; k < 4; k++) begin
                mem_c[i][k] = '0;
                mem_f[i][k] = '0;
            end
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R8", DW'(rvalid_c), DW'(0));
        chk("R8", rdata_c, '0);
        rst_n = 1'b1;
        do_read(8'h27, "R8");

        // full write at word 5, then read from every start slot (R2, R3)
        d = {16'hD3D3, 16'hC2C2, 16'hB1B1, 16'hA0A0};
        en = '1;
        do_write({6'd5, 2'd0}, d, en, 1'b0);
        for (int s = 0; s < 4; s++) do_read({6'd5, 2'(s)}, "R3");
        // second word commits word 5 into storage; re-read it (R2)
        d = {16'h4444, 16'h3333, 16'h2222, 16'h1111};
        do_write({6'd9, 2'd2}, d, en, 1'b0);
        do_read({6'd5, 2'd1}, "R2");
        do_read({6'd9, 2'd3}, "R3");

        // partial lanes onto word 5 read at once (R5, R6 via pending bypass)
        d = {16'hEEEE, 16'hDDDD, 16'hCCCC, 16'hBBBB};
        en = {2'b00, 2'b11, 2'b10, 2'b01};
        do_write({6'd5, 2'd3}, d, en, 1'b0);
        do_read({6'd5, 2'd0}, "R5");
        do_read({6'd5, 2'd2}, "R6");

        // read strobe held during a write burst (R7)
        d = {16'h0F0F, 16'hF0F0, 16'h5A5A, 16'hA5A5};
        en = '1;
        do_write({6'd12, 2'd1}, d, en, 1'b1);
        do_read({6'd12, 2'd1}, "R7");

        // seeded random mix
        for (int n = 0; n < 400; n++) begin
            logic [IDX_W+1:0] a;
            a = (IDX_W + 2)'($urandom % 32);
            if ($urandom % 2 == 0) begin
                for (int k = 0; k < 4; k++) begin
                    d[k]  = DW'($urandom);
                    en[k] = LANES'($urandom);
                end
                do_write(a, d, en, 1'b0);
            end else begin
                do_read(a, "R6");
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule